// File: doc/BRIEF.md
# NAND Program/Erase Command Sequencer

This block sits behind the byte-wide command interface of a NAND flash model. It reads command, address and data strobes one at a time and recognises the two-step program, erase and copy-back sequences. It also handles the status-read command and the reset command. An accepted operation pulls the ready/busy output low for a fixed, parameterised number of clock cycles. Array programming itself is not modelled. Instead, a ledger counts how many partial programs each page has received in its main and spare areas. Those counts are checked against limits before any program or copy-back may start.

An operation can be refused for three reasons: the write-protect input is low, the page has reached its partial-program limit, or a copy-back crosses planes. A refused operation never goes busy. It sets the fail bit in the status byte at once and leaves the ledger unchanged.

The controller moves through these named states:

- `S_IDLE`
- program path: `S_PG_COL`, `S_PG_ROW`, `S_PG_DATA0`, `S_PG_DATA`
- erase path: `S_ER_ROW`, `S_ER_CONF`
- copy-back path: `S_CB_SRC`, `S_CB_DST`, `S_CB_CONF`
- `S_BUSY`

The transitions are:

- **Setup:** `S_IDLE` leaves on a setup command (80h, 60h, 8Ah).
- **Address:** each address strobe advances one step along its path.
- **First data byte:** a data byte moves `S_PG_DATA0` to `S_PG_DATA`.
- **Confirm:** a confirm command goes to `S_BUSY` when the operation is accepted, and to `S_IDLE` when it is refused.
- **Any other command:** from any waiting state it goes back to idle decoding.
- **Completion:** `S_BUSY` returns to `S_IDLE` when the busy timer completes.
- **Reset:** a reset command returns to `S_IDLE` from any state.

Top module: `nandseq_top`

## Requirements
- R1: After rst_n is released, ready_busy is 1, bus_out is 00h, and a status read returns C0h while wp_n is 1.
- R2: After command 70h, bus_out carries the status byte {bit7 = wp_n, bit6 = ready_busy, bits 5..1 = 0, bit0 = fail}. Any later command other than 70h makes bus_out 00h.
- R3: The sequence 60h, one row address strobe, D0h starts an erase. ready_busy is 0 for exactly ERASE_CYC cycles, starting in the cycle after the D0h strobe. Fail then reads 0. The partial-program counts of every page whose row shares bits [ROW_W-1:BLK_LOG2] with the given row return to zero.
- R4: The sequence 80h, column strobe, row strobe, at least one data strobe, 10h starts a program. ready_busy is 0 for exactly PROG_CYC cycles. A 10h that arrives before any data byte is discarded without going busy.
- R5: After a setup command, any command other than its own confirm discards the sequence, with no busy and no fail change. That command is then decoded as though the block were idle.
- R6: With wp_n at 0, a confirmed program, erase or copy-back does not go busy. It sets fail in the following cycle and leaves the partial-program counts unchanged.
- R7: Bit 7 of the column byte selects the spare area (1) or the main area (0). Without an erase in between, a page accepts at most MAIN_LIMIT (2) main-area programs and SPARE_LIMIT (3) spare-area programs. A program beyond its limit does not go busy and sets fail.
- R8: The sequence 8Ah, source row strobe, destination row strobe, 10h starts a copy-back. It is accepted only if row bit PLANE_BIT (2) matches between source and destination and both destination counts are below their limits. An accepted copy-back is busy for PROG_CYC cycles and adds one to both destination counts. A refused one sets fail without going busy.
- R9: Command FFh stops any busy period. ready_busy is 1 in the next cycle, fail clears, and the status reads C0h with wp_n at 1 or 40h with wp_n at 0.
- R10: While busy, the block ignores every command except 70h and FFh, and it ignores address and data strobes.
- R11: A launched operation clears fail.
- R12: An FFh that arrives in the last busy cycle gives the same result as an FFh arriving earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write protect, low blocks program, erase and copy-back |
| cmd_we | input | 1 | Command strobe, bus_in holds a command byte |
| addr_we | input | 1 | Address strobe, bus_in holds an address byte |
| data_we | input | 1 | Data strobe, bus_in holds a data byte |
| bus_in | input | 8 | Input byte |
| bus_out | output | 8 | Status byte while in status-read mode, else 00h |
| ready_busy | output | 1 | 1 when ready, 0 while an operation runs |

## Verification
Two events can land on the same clock edge: a reset command arriving in the final busy cycle and the busy timer expiring. The bench counts cycles from the confirm strobe so that FFh is captured on exactly the edge where the timer would finish. It then checks three things: ready_busy is high, the status reads C0h, and the next program runs for its full length, showing the timer restarted cleanly. A second overlap is a status read, or a new setup sequence, issued during busy. This is judged by checking that the total busy length is unchanged and that a later confirm starts nothing.

// File: rtl/nandseq_pkg.sv
package nandseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PG_COL,
        S_PG_ROW,
        S_PG_DATA0,
        S_PG_DATA,
        S_ER_ROW,
        S_ER_CONF,
        S_CB_SRC,
        S_CB_DST,
        S_CB_CONF,
        S_BUSY
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_PROG,
        OP_ERASE,
        OP_COPY
    } op_kind_t;

    localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
    localparam logic [7:0] CMD_PROG_GO     = 8'h10;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_COPY_SETUP  = 8'h8A;
    localparam logic [7:0] CMD_STATUS      = 8'h70;
    localparam logic [7:0] CMD_RESET       = 8'hFF;

endpackage

// File: rtl/nandseq_cmd_fsm.sv
module nandseq_cmd_fsm
    import nandseq_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic             addr_we,
    input  logic             data_we,
    input  logic [7:0]       bus_in,
    input  logic             launch,
    input  logic             busy_done,
    output logic             op_req,
    output logic             abort,
    output op_kind_t         op_kind,
    output logic             area_spare,
    output logic [ROW_W-1:0] row_src,
    output logic [ROW_W-1:0] row_dst
);

    seq_state_t       state_q, state_d;
    logic             spare_q, spare_d;
    logic [ROW_W-1:0] src_q, src_d;
    logic [ROW_W-1:0] dst_q, dst_d;

    function automatic seq_state_t decode_setup(input logic [7:0] c);
        seq_state_t s;
        case (c)
            CMD_PROG_SETUP:  s = S_PG_COL;
            CMD_ERASE_SETUP: s = S_ER_ROW;
            CMD_COPY_SETUP:  s = S_CB_SRC;
            default:         s = S_IDLE;
        endcase
        return s;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            spare_q <= 1'b0;
            src_q   <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            spare_q <= spare_d;
            src_q   <= src_d;
            dst_q   <= dst_d;
        end
    end

    // outputs: confirm recognition and abort
    always_comb begin
        abort   = cmd_we && (bus_in == CMD_RESET);
        op_req  = 1'b0;
        op_kind = OP_PROG;
        unique case (state_q)
            S_PG_DATA: op_req = cmd_we && (bus_in == CMD_PROG_GO);
            S_ER_CONF: begin
                op_kind = OP_ERASE;
                op_req  = cmd_we && (bus_in == CMD_ERASE_GO);
            end
            S_CB_CONF: begin
                op_kind = OP_COPY;
                op_req  = cmd_we && (bus_in == CMD_PROG_GO);
            end
            default: ;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        spare_d = spare_q;
        src_d   = src_q;
        dst_d   = dst_q;
        if (abort) begin
            state_d = S_IDLE;
        end else if (state_q == S_BUSY) begin
            if (busy_done) state_d = S_IDLE;
        end else if (cmd_we) begin
            if (op_req) state_d = launch ? S_BUSY : S_IDLE;
            else        state_d = decode_setup(bus_in);
        end else if (addr_we) begin
            unique case (state_q)
                S_PG_COL: begin
                    spare_d = bus_in[7];
                    state_d = S_PG_ROW;
                end
                S_PG_ROW: begin
                    dst_d   = bus_in[ROW_W-1:0];
                    state_d = S_PG_DATA0;
                end
                S_ER_ROW: begin
                    dst_d   = bus_in[ROW_W-1:0];
                    state_d = S_ER_CONF;
                end
                S_CB_SRC: begin
                    src_d   = bus_in[ROW_W-1:0];
                    state_d = S_CB_DST;
                end
                S_CB_DST: begin
                    dst_d   = bus_in[ROW_W-1:0];
                    state_d = S_CB_CONF;
                end
                default: ;
            endcase
        end else if (data_we && (state_q == S_PG_DATA0)) begin
            state_d = S_PG_DATA;
        end
    end

    assign area_spare = spare_q;
    assign row_src    = src_q;
    assign row_dst    = dst_q;

endmodule

// File: rtl/nandseq_page_ledger.sv
module nandseq_page_ledger
    import nandseq_pkg::*;
#(
    parameter int ROW_W       = 4,
    parameter int BLK_LOG2    = 2,
    parameter int PLANE_BIT   = 2,
    parameter int MAIN_LIMIT  = 2,
    parameter int SPARE_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_kind_t         op_kind,
    input  logic             area_spare,
    input  logic [ROW_W-1:0] row_src,
    input  logic [ROW_W-1:0] row_dst,
    input  logic             commit,
    output logic             op_ok
);

    localparam int PAGES   = 1 << ROW_W;
    localparam int MAX_LIM = (MAIN_LIMIT > SPARE_LIMIT) ? MAIN_LIMIT : SPARE_LIMIT;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] MAIN_TOP  = CNT_W'(MAIN_LIMIT);
    localparam logic [CNT_W-1:0] SPARE_TOP = CNT_W'(SPARE_LIMIT);

    logic [CNT_W-1:0] main_cnt  [PAGES];
    logic [CNT_W-1:0] spare_cnt [PAGES];
    logic [PAGES-1:0] in_block;

    for (genvar g = 0; g < PAGES; g++) begin : g_blk
        localparam logic [ROW_W-1:0] PG = ROW_W'(g);
        assign in_block[g] = (row_dst[ROW_W-1:BLK_LOG2] == PG[ROW_W-1:BLK_LOG2]);
    end

    logic main_room, spare_room, plane_same;
    assign main_room  = main_cnt[row_dst]  < MAIN_TOP;
    assign spare_room = spare_cnt[row_dst] < SPARE_TOP;
    assign plane_same = row_src[PLANE_BIT] == row_dst[PLANE_BIT];

    always_comb begin
        unique case (op_kind)
            OP_PROG:  op_ok = area_spare ? spare_room : main_room;
            OP_ERASE: op_ok = 1'b1;
            OP_COPY:  op_ok = plane_same && main_room && spare_room;
            default:  op_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) begin
                main_cnt[p]  <= '0;
                spare_cnt[p] <= '0;
            end
        end else if (commit) begin
            unique case (op_kind)
                OP_PROG: begin
                    if (area_spare) spare_cnt[row_dst] <= spare_cnt[row_dst] + 1'b1;
                    else            main_cnt[row_dst]  <= main_cnt[row_dst] + 1'b1;
                end
                OP_ERASE: begin
                    for (int p = 0; p < PAGES; p++) begin
                        if (in_block[p]) begin
                            main_cnt[p]  <= '0;
                            spare_cnt[p] <= '0;
                        end
                    end
                end
                OP_COPY: begin
                    main_cnt[row_dst]  <= main_cnt[row_dst] + 1'b1;
                    spare_cnt[row_dst] <= spare_cnt[row_dst] + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nandseq_busy_timer.sv
module nandseq_busy_timer #(
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_erase,
    input  logic abort,
    output logic busy,
    output logic done
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (abort)         cnt_q <= '0;
        else if (load)          cnt_q <= load_erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1)) && !abort;

endmodule

// File: rtl/nandseq_top.sv
module nandseq_top
    import nandseq_pkg::*;
#(
    parameter int ROW_W       = 4,
    parameter int BLK_LOG2    = 2,
    parameter int PLANE_BIT   = 2,
    parameter int MAIN_LIMIT  = 2,
    parameter int SPARE_LIMIT = 3,
    parameter int PROG_CYC    = 6,
    parameter int ERASE_CYC   = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_n,
    input  logic       cmd_we,
    input  logic       addr_we,
    input  logic       data_we,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       ready_busy
);

    localparam int MAX_BUSY_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;

    logic             op_req, abort, area_spare, op_ok, launch;
    logic             busy, busy_done;
    op_kind_t         op_kind;
    logic [ROW_W-1:0] row_src, row_dst;
    logic             fail_q, stat_q;

    nandseq_cmd_fsm #(.ROW_W(ROW_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .addr_we    (addr_we),
        .data_we    (data_we),
        .bus_in     (bus_in),
        .launch     (launch),
        .busy_done  (busy_done),
        .op_req     (op_req),
        .abort      (abort),
        .op_kind    (op_kind),
        .area_spare (area_spare),
        .row_src    (row_src),
        .row_dst    (row_dst)
    );

    nandseq_page_ledger #(
        .ROW_W      (ROW_W),
        .BLK_LOG2   (BLK_LOG2),
        .PLANE_BIT  (PLANE_BIT),
        .MAIN_LIMIT (MAIN_LIMIT),
        .SPARE_LIMIT(SPARE_LIMIT)
    ) u_ledger (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_kind    (op_kind),
        .area_spare (area_spare),
        .row_src    (row_src),
        .row_dst    (row_dst),
        .commit     (launch),
        .op_ok      (op_ok)
    );

    nandseq_busy_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (launch),
        .load_erase (op_kind == OP_ERASE),
        .abort      (abort),
        .busy       (busy),
        .done       (busy_done)
    );

    assign launch = op_req && wp_n && op_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            if (abort)       fail_q <= 1'b0;
            else if (op_req) fail_q <= !launch;
            if (cmd_we)      stat_q <= (bus_in == CMD_STATUS);
        end
    end

    assign ready_busy = !busy;
    assign bus_out    = stat_q ? {wp_n, ready_busy, 5'b00000, fail_q} : 8'h00;

endmodule

// File: rtl/nandseq_checker.sv
module nandseq_checker #(
    parameter int MAX_BUSY = 9
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       cmd_we,
    input logic [7:0] bus_in,
    input logic [7:0] bus_out,
    input logic       ready_busy,
    input logic       launch,
    input logic       op_req
);

    localparam int LW = $clog2(MAX_BUSY + 2) + 1;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= '0;
        else if (ready_busy) low_run <= '0;
        else                 low_run <= low_run + 1'b1;
    end

    // R3 / R4: a launched operation drops ready in the next cycle
    assert_launch_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !ready_busy);

    assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !wp_n) |=> ready_busy);

    assert_abort_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && bus_in == 8'hFF) |=> ready_busy);

    // R2: reset command leaves status-read mode
    assert_abort_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && bus_in == 8'hFF) |=> (bus_out == 8'h00));

    // R10: busy starts only from a confirm with write enable high
    assert_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_busy) |-> ($past(cmd_we) && $past(wp_n) &&
                               ($past(bus_in) == 8'h10 || $past(bus_in) == 8'hD0)));

    // R3: a busy period never outlasts the longest programmed duration
    assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= LW'(MAX_BUSY));

endmodule

bind nandseq_top nandseq_checker #(.MAX_BUSY(MAX_BUSY_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n       (wp_n),
    .cmd_we     (cmd_we),
    .bus_in     (bus_in),
    .bus_out    (bus_out),
    .ready_busy (ready_busy),
    .launch     (launch),
    .op_req     (op_req)
);

// File: tb/nandseq_top_test.sv
module nandseq_top_test;

    localparam int ROW_W = 4, PAGES = 16, BLK_LOG2 = 2, PLANE_BIT = 2;
    localparam int MLIM = 2, SLIM = 3, PCYC = 6, ECYC = 9;

    logic       clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
    logic       cmd_we = 1'b0, addr_we = 1'b0, data_we = 1'b0;
    logic [7:0] bus_in = 8'h00;
    wire  [7:0] bus_out;
    wire        ready_busy;

    int vec = 0, fails = 0;
    bit finished = 0;
    int mc [PAGES];
    int sc [PAGES];

    always #5 clk = ~clk;

    nandseq_top #(
        .ROW_W(ROW_W), .BLK_LOG2(BLK_LOG2), .PLANE_BIT(PLANE_BIT),
        .MAIN_LIMIT(MLIM), .SPARE_LIMIT(SLIM), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_we(cmd_we),
        .addr_we(addr_we), .data_we(data_we), .bus_in(bus_in),
        .bus_out(bus_out), .ready_busy(ready_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        vec++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // kind 0 = command, 1 = address, 2 = data
    task automatic strobe(input int kind, input logic [7:0] b);
        @(negedge clk);
        bus_in  = b;
        cmd_we  = (kind == 0);
        addr_we = (kind == 1);
        data_we = (kind == 2);
        @(negedge clk);
        cmd_we = 1'b0; addr_we = 1'b0; data_we = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready_busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic status_is(input string req, input logic [7:0] exp);
        strobe(0, 8'h70);
        chk(req, bus_out, exp);
    endtask

    task automatic do_prog(input int row, input bit spare);
        bit ok;
        int n;
        ok = spare ? (sc[row] < SLIM) : (mc[row] < MLIM);
        strobe(0, 8'h80);
        strobe(1, spare ? 8'h80 : 8'h00);
        strobe(1, 8'(row));
        strobe(2, 8'hA5);
        strobe(2, 8'h5A);
        strobe(0, 8'h10);
        if (ok) begin
            wait_ready(n);
            chk("R4 program busy length", n, PCYC);
            if (spare) sc[row]++; else mc[row]++;
            status_is("R11 status after program", 8'hC0);
        end else begin
            chk("R7 over-limit program stays ready", ready_busy, 1);
            status_is("R7 over-limit program fail", 8'hC1);
        end
    endtask

    task automatic do_erase(input int row);
        int n;
        strobe(0, 8'h60);
        strobe(1, 8'(row));
        strobe(0, 8'hD0);
        wait_ready(n);
        chk("R3 erase busy length", n, ECYC);
        for (int p = 0; p < PAGES; p++)
            if ((p >> BLK_LOG2) == (row >> BLK_LOG2)) begin
                mc[p] = 0;
                sc[p] = 0;
            end
        status_is("R3 status after erase", 8'hC0);
    endtask

    task automatic do_copy(input int src, input int dst);
        bit ok;
        int n;
        ok = (((src >> PLANE_BIT) & 1) == ((dst >> PLANE_BIT) & 1))
             && (mc[dst] < MLIM) && (sc[dst] < SLIM);
        strobe(0, 8'h8A);
        strobe(1, 8'(src));
        strobe(1, 8'(dst));
        strobe(0, 8'h10);
        if (ok) begin
            wait_ready(n);
            chk("R8 copy-back busy length", n, PCYC);
            mc[dst]++;
            sc[dst]++;
            status_is("R8 copy-back status ok", 8'hC0);
        end else begin
            chk("R8 refused copy-back stays ready", ready_busy, 1);
            status_is("R8 refused copy-back fail", 8'hC1);
        end
    endtask

    task automatic erase_all();
        for (int b = 0; b < (PAGES >> BLK_LOG2); b++) do_erase(b << BLK_LOG2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
            $finish;
        end
    end

    initial begin
        int n;
        for (int p = 0; p < PAGES; p++) begin mc[p] = 0; sc[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready after reset", ready_busy, 1);
        chk("R1 bus idle after reset", bus_out, 8'h00);
        status_is("R1 status after reset", 8'hC0);

        // R2 status format and leaving status mode
        wp_n = 1'b0;
        #1 chk("R2 status tracks wp_n", bus_out, 8'h40);
        @(negedge clk);
        wp_n = 1'b1;
        strobe(0, 8'h00);
        chk("R2 other command ends status mode", bus_out, 8'h00);

        // R7 sweep: every page, both areas, up to limit plus one
        for (int p = 0; p < PAGES; p++)
            for (int a = 0; a < 2; a++)
                for (int i = 0; i <= (a ? SLIM : MLIM); i++)
                    do_prog(p, a[0]);

        // R3 erase restores counts
        erase_all();
        for (int p = 0; p < PAGES; p += 5) do_prog(p, 1'b0);

        // R8 copy-back sweep over all source/destination pairs
        for (int s = 0; s < PAGES; s++)
            for (int d = 0; d < PAGES; d++)
                do_copy(s, d);
        erase_all();

        // R4 confirm before any data byte is discarded
        strobe(0, 8'h80); strobe(1, 8'h00); strobe(1, 8'h01); strobe(0, 8'h10);
        chk("R4 program without data not started", ready_busy, 1);
        status_is("R4 program without data no fail", 8'hC0);

        // R5 discarded setup; the new command is decoded fresh
        strobe(0, 8'h80); strobe(1, 8'h00); strobe(1, 8'h05);
        strobe(0, 8'h60); strobe(1, 8'h05); strobe(0, 8'hD0);
        wait_ready(n);
        chk("R5 erase after discarded program", n, ECYC);
        strobe(0, 8'h60); strobe(1, 8'h06); strobe(0, 8'h70);
        chk("R5 status command cancels erase setup", bus_out, 8'hC0);
        strobe(0, 8'hD0);
        chk("R5 stray confirm ignored", ready_busy, 1);
        strobe(0, 8'h8A); strobe(1, 8'h01); strobe(1, 8'h02); strobe(0, 8'hD0);
        chk("R5 copy-back with wrong confirm", ready_busy, 1);
        status_is("R5 discard leaves fail clear", 8'hC0);

        // R6 write protect
        do_prog(3, 1'b0);
        wp_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            strobe(0, 8'h80); strobe(1, 8'h00); strobe(1, 8'h03);
            strobe(2, 8'h11); strobe(0, 8'h10);
            chk("R6 protected program not busy", ready_busy, 1);
        end
        strobe(0, 8'h60); strobe(1, 8'h03); strobe(0, 8'hD0);
        chk("R6 protected erase not busy", ready_busy, 1);
        strobe(0, 8'h8A); strobe(1, 8'h01); strobe(1, 8'h03); strobe(0, 8'h10);
        chk("R6 protected copy-back not busy", ready_busy, 1);
        status_is("R6 protected fail status", 8'h41);
        strobe(0, 8'hFF);
        status_is("R9 reset clears fail under protect", 8'h40);
        wp_n = 1'b1;
        do_prog(3, 1'b0);
        do_prog(3, 1'b0);

        // R10 commands and strobes during busy are ignored; 70h still works
        strobe(0, 8'h60); strobe(1, 8'h08); strobe(0, 8'hD0);
        for (int p = 8; p < 12; p++) begin mc[p] = 0; sc[p] = 0; end
        strobe(0, 8'h70);
        chk("R10 status during busy", bus_out, 8'h80);
        strobe(0, 8'h80); strobe(1, 8'h00); strobe(1, 8'h09);
        wait_ready(n);
        chk("R10 busy length unaffected", n + 8, ECYC);
        strobe(2, 8'h33);
        strobe(0, 8'h10);
        chk("R10 setup during busy was dropped", ready_busy, 1);
        status_is("R10 no fail after drops", 8'hC0);

        // R9 abort mid-busy
        strobe(0, 8'h60); strobe(1, 8'h00); strobe(0, 8'hD0);
        for (int p = 0; p < 4; p++) begin mc[p] = 0; sc[p] = 0; end
        repeat (3) @(negedge clk);
        chk("R9 still busy before abort", ready_busy, 0);
        strobe(0, 8'hFF);
        chk("R9 ready after abort", ready_busy, 1);
        status_is("R9 status after abort", 8'hC0);

        // R12 abort landing on the final busy cycle
        strobe(0, 8'h80); strobe(1, 8'h00); strobe(1, 8'h00);
        strobe(2, 8'h00); strobe(0, 8'h10);
        mc[0]++;
        repeat (PCYC - 2) @(negedge clk);
        chk("R12 busy in final cycle", ready_busy, 0);
        strobe(0, 8'hFF);
        chk("R12 ready after late abort", ready_busy, 1);
        status_is("R12 status after late abort", 8'hC0);
        do_prog(0, 1'b0);
        do_prog(0, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

endmodule